// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block keeps program order for instructions that run out of order. Each cycle dispatch asks for a group of up to four slots. When the whole group fits, the block returns one tag per instruction, taken consecutively from the tail of a 16-slot circular buffer. Execution units report completion by tag on three finish ports. Each report can also raise an exception flag for that slot.

Each cycle the block looks at the four oldest slots and retires the finished ones in order. It stops at the first slot that has not finished. An exception takes effect only when the excepting slot is next in line to retire. That slot is then reported on its own output and is not retired, and the whole buffer is emptied. A branch mispredict names the branch's tag, and every slot allocated after that branch is dropped.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty. No slot retires, no exception is reported, and a request for four slots is granted with tags 0 to 3.
- R2: A granted group of N slots (N from 1 to 4) gets the tags tail, tail+1, ... tail+N-1, modulo 16. The tail then moves forward by N at the next clock.
- R3: A group is granted only when there are at least N free slots. A refused group allocates nothing, so the next granted group starts at the same tag.
- R4: A slot retires only when it is finished and every older slot retires before it or in the same cycle. Retirement stops at the first unfinished slot.
- R5: Up to four slots retire per cycle. The retire valid bits are contiguous from bit 0, and bit i carries tag head+i.
- R6: A mispredict naming tag B removes every slot younger than B. The next allocation gets tag B+1.
- R7: When the oldest non-retiring slot in the window is finished with its exception flag set, the block raises the exception valid output for exactly one cycle with that slot's tag. That slot does not retire, and the buffer is empty at the next clock.
- R8: No allocation is granted in a cycle with a mispredict or a recognised exception.
- R9: Tags wrap from 15 to 0. When all 16 slots are in use, even a single-slot request is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_num_i | input | 3 | Number of slots requested this cycle (0 to 4) |
| alloc_ok_o | output | 1 | Request granted |
| alloc_tag_o | output | 16 | Four 4-bit tags, the oldest in bits 3:0 |
| fin_vld_i | input | 3 | Finish report valid, one bit per port |
| fin_tag_i | input | 12 | Finish tags, 4 bits per port |
| fin_exc_i | input | 3 | Exception flag for each finish port |
| flush_vld_i | input | 1 | Branch mispredict |
| flush_tag_i | input | 4 | Tag of the mispredicted branch |
| ret_vld_o | output | 4 | Retire valid, bit 0 is the oldest slot |
| ret_tag_o | output | 16 | Tags of the retiring slots, 4 bits each |
| exc_vld_o | output | 1 | Exception recognised this cycle |
| exc_tag_o | output | 4 | Tag of the excepting slot |

## Verification
The grant and the tags depend combinationally on the state and on the request. The bench therefore checks them within the same cycle, one time unit after it drives the request. A finish report is written at the next clock edge. The resulting retire pattern or exception is visible right after that edge and is committed at the edge after. Each scenario task drives its stimulus, advances one clock, and checks the retire and exception outputs in the very next cycle, before the automatic retirement can move the head. The effects of a flush and of a refused group are checked through the tag returned by the next allocation.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic fin;
    logic exc;
  } rob_ent_t;
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1,
  localparam int CNT_W = $clog2(DISP_W + 1)
) (
  input  logic [PTR_W-1:0]        head_i,
  input  logic [PTR_W-1:0]        tail_i,
  input  logic [CNT_W-1:0]        alloc_num_i,
  input  logic                    block_i,
  output logic                    alloc_ok_o,
  output logic [DISP_W-1:0]       alloc_en_o,
  output logic [DISP_W*TAG_W-1:0] alloc_tag_o
);
  logic [PTR_W-1:0] used, free;

  assign used       = tail_i - head_i;
  assign free       = PTR_W'(DEPTH) - used;
  assign alloc_ok_o = !block_i && (PTR_W'(alloc_num_i) <= free);

  for (genvar i = 0; i < DISP_W; i++) begin : g_tag
    assign alloc_tag_o[i*TAG_W +: TAG_W] = TAG_W'(tail_i + PTR_W'(i));
    assign alloc_en_o[i] = alloc_ok_o && (CNT_W'(i) < alloc_num_i);
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int FIN_W  = 3,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DISP_W-1:0]       alloc_en_i,
  input  logic [DISP_W*TAG_W-1:0] alloc_tag_i,
  input  logic [FIN_W-1:0]        fin_vld_i,
  input  logic [FIN_W*TAG_W-1:0]  fin_tag_i,
  input  logic [FIN_W-1:0]        fin_exc_i,
  output logic [DEPTH-1:0]        fin_o,
  output logic [DEPTH-1:0]        exc_o
);
  rob_ent_t ent_q [DEPTH];

  // allocated and finishing slots never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else begin
      for (int i = 0; i < DISP_W; i++)
        if (alloc_en_i[i]) ent_q[alloc_tag_i[i*TAG_W +: TAG_W]] <= '0;
      for (int j = 0; j < FIN_W; j++)
        if (fin_vld_i[j])
          ent_q[fin_tag_i[j*TAG_W +: TAG_W]] <= '{fin: 1'b1, exc: fin_exc_i[j]};
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_out
    assign fin_o[k] = ent_q[k].fin;
    assign exc_o[k] = ent_q[k].exc;
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DEPTH = 16,
  parameter int RET_W = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1,
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic [PTR_W-1:0]       head_i,
  input  logic [PTR_W-1:0]       count_i,
  input  logic [DEPTH-1:0]       fin_i,
  input  logic [DEPTH-1:0]       exc_i,
  output logic [RET_W-1:0]       ret_vld_o,
  output logic [RET_W*TAG_W-1:0] ret_tag_o,
  output logic [RCNT_W-1:0]      ret_cnt_o,
  output logic                   exc_vld_o,
  output logic [TAG_W-1:0]       exc_tag_o
);
  logic [TAG_W-1:0] slot [RET_W];

  for (genvar i = 0; i < RET_W; i++) begin : g_slot
    assign slot[i] = TAG_W'(head_i + PTR_W'(i));
    assign ret_tag_o[i*TAG_W +: TAG_W] = slot[i];
  end

  always_comb begin
    logic run;
    run       = 1'b1;
    ret_vld_o = '0;
    ret_cnt_o = '0;
    exc_vld_o = 1'b0;
    exc_tag_o = '0;
    for (int i = 0; i < RET_W; i++) begin
      if (run && (PTR_W'(i) < count_i) && fin_i[slot[i]]) begin
        if (exc_i[slot[i]]) begin
          exc_vld_o = 1'b1;
          exc_tag_o = slot[i];
          run       = 1'b0;
        end else begin
          ret_vld_o[i] = 1'b1;
          ret_cnt_o    = ret_cnt_o + RCNT_W'(1);
        end
      end else begin
        run = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rob_top.sv
module rob_top #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int FIN_W  = 3,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int PTR_W  = TAG_W + 1,
  localparam int CNT_W  = $clog2(DISP_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        alloc_num_i,
  output logic                    alloc_ok_o,
  output logic [DISP_W*TAG_W-1:0] alloc_tag_o,
  input  logic [FIN_W-1:0]        fin_vld_i,
  input  logic [FIN_W*TAG_W-1:0]  fin_tag_i,
  input  logic [FIN_W-1:0]        fin_exc_i,
  input  logic                    flush_vld_i,
  input  logic [TAG_W-1:0]        flush_tag_i,
  output logic [RET_W-1:0]        ret_vld_o,
  output logic [RET_W*TAG_W-1:0]  ret_tag_o,
  output logic                    exc_vld_o,
  output logic [TAG_W-1:0]        exc_tag_o
);
  logic [PTR_W-1:0]  head_q, tail_q, head_d, tail_d, count;
  logic [DISP_W-1:0] alloc_en;
  logic [DEPTH-1:0]  fin_st, exc_st;
  logic [RCNT_W-1:0] ret_cnt;
  logic [TAG_W-1:0]  br_off;

  assign count  = tail_q - head_q;
  assign br_off = flush_tag_i - head_q[TAG_W-1:0];

  rob_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W)) alloc_i (
    .head_i      (head_q),
    .tail_i      (tail_q),
    .alloc_num_i (alloc_num_i),
    .block_i     (flush_vld_i || exc_vld_o),
    .alloc_ok_o  (alloc_ok_o),
    .alloc_en_o  (alloc_en),
    .alloc_tag_o (alloc_tag_o)
  );

  rob_entries #(.DEPTH(DEPTH), .DISP_W(DISP_W), .FIN_W(FIN_W)) ent_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_en_i  (alloc_en),
    .alloc_tag_i (alloc_tag_o),
    .fin_vld_i   (fin_vld_i),
    .fin_tag_i   (fin_tag_i),
    .fin_exc_i   (fin_exc_i),
    .fin_o       (fin_st),
    .exc_o       (exc_st)
  );

  rob_retire #(.DEPTH(DEPTH), .RET_W(RET_W)) ret_i (
    .head_i    (head_q),
    .count_i   (count),
    .fin_i     (fin_st),
    .exc_i     (exc_st),
    .ret_vld_o (ret_vld_o),
    .ret_tag_o (ret_tag_o),
    .ret_cnt_o (ret_cnt),
    .exc_vld_o (exc_vld_o),
    .exc_tag_o (exc_tag_o)
  );

  // exception empties everything and outranks a mispredict
  always_comb begin
    head_d = head_q + PTR_W'(ret_cnt);
    if (exc_vld_o)        tail_d = head_d;
    else if (flush_vld_i) tail_d = head_q + PTR_W'(br_off) + PTR_W'(1);
    else if (alloc_ok_o)  tail_d = tail_q + PTR_W'(alloc_num_i);
    else                  tail_d = tail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end
endmodule

// File: rtl/rob_top_chk.sv
module rob_top_chk #(
  parameter int DEPTH = 16,
  parameter int RET_W = 4,
  parameter int PTR_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PTR_W-1:0] head_q,
  input logic [PTR_W-1:0] tail_q,
  input logic             alloc_ok_o,
  input logic             flush_vld_i,
  input logic             exc_vld_o,
  input logic [RET_W-1:0] ret_vld_o
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PTR_W'(tail_q - head_q) <= PTR_W'(DEPTH));

  a_r8_flush_blocks_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_vld_i |-> !alloc_ok_o);

  a_r7_exc_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_vld_o |=> !exc_vld_o);

  a_r7_exc_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_vld_o |=> (tail_q == head_q));

  a_r5_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RET_W'(ret_vld_o + 1'b1) & ret_vld_o) == '0);

  a_r4_head_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> head_q == PTR_W'($past(head_q) + PTR_W'($countones($past(ret_vld_o)))));
endmodule

bind rob_top rob_top_chk #(.DEPTH(DEPTH), .RET_W(RET_W), .PTR_W(PTR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .head_q      (head_q),
  .tail_q      (tail_q),
  .alloc_ok_o  (alloc_ok_o),
  .flush_vld_i (flush_vld_i),
  .exc_vld_o   (exc_vld_o),
  .ret_vld_o   (ret_vld_o)
);

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  alloc_num_i;
  logic        alloc_ok_o;
  logic [15:0] alloc_tag_o;
  logic [2:0]  fin_vld_i, fin_exc_i;
  logic [11:0] fin_tag_i;
  logic        flush_vld_i;
  logic [3:0]  flush_tag_i;
  logic [3:0]  ret_vld_o;
  logic [15:0] ret_tag_o;
  logic        exc_vld_o;
  logic [3:0]  exc_tag_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rob_top dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_num_i = '0; fin_vld_i = '0; fin_exc_i = '0; fin_tag_i = '0;
    flush_vld_i = 1'b0; flush_tag_i = '0;
  endtask

  task automatic step();
    @(posedge clk_i); #5; idle();
  endtask

  task automatic alloc(int n, bit exp_ok, int exp_tag0, string req);
    alloc_num_i = 3'(n);
    #1;
    check({req, " grant"}, int'(alloc_ok_o), int'(exp_ok));
    if (exp_ok) check({req, " tag"}, int'(alloc_tag_o[3:0]), exp_tag0);
    step();
  endtask

  task automatic finish(logic [2:0] vld, int t0, int t1, int t2, logic [2:0] exc);
    fin_vld_i = vld; fin_exc_i = exc;
    fin_tag_i = {4'(t2), 4'(t1), 4'(t0)};
    step();
  endtask

  task automatic expect_ret(logic [3:0] mask, int tag0, string req);
    #1;
    check({req, " retire mask"}, int'(ret_vld_o), int'(mask));
    for (int i = 0; i < 4; i++)
      if (mask[i]) check({req, " retire tag"}, int'(ret_tag_o[i*4 +: 4]), (tag0 + i) % 16);
    check({req, " no exception"}, int'(exc_vld_o), 0);
    step();
  endtask

  task automatic test_reset();
    alloc_num_i = 3'd4;
    #1;
    check("R1 grant", int'(alloc_ok_o), 1);
    check("R1 tag0", int'(alloc_tag_o[3:0]), 0);
    check("R1 tag3", int'(alloc_tag_o[15:12]), 3);
    check("R1 retire", int'(ret_vld_o), 0);
    check("R1 exception", int'(exc_vld_o), 0);
    idle();
  endtask

  task automatic test_inorder();
    alloc(4, 1, 0, "R2");
    alloc(3, 1, 4, "R2");
    finish(3'b011, 1, 2, 0, 3'b000);
    expect_ret(4'b0000, 0, "R4 head unfinished");
    finish(3'b001, 0, 0, 0, 3'b000);
    expect_ret(4'b0111, 0, "R4");
    finish(3'b111, 4, 5, 6, 3'b000);
    expect_ret(4'b0000, 0, "R4 stop at first unfinished");
    finish(3'b001, 3, 0, 0, 3'b000);
    expect_ret(4'b1111, 3, "R5");
  endtask

  task automatic test_full();
    alloc(4, 1, 7, "R2");
    alloc(4, 1, 11, "R2");
    alloc(4, 1, 15, "R9 wrap");
    alloc(2, 1, 3, "R9");
    alloc(4, 0, 0, "R3 group refused");
    alloc(2, 1, 5, "R3 nothing taken on refusal");
    alloc(1, 0, 0, "R9 full");
  endtask

  task automatic test_flush();
    flush_vld_i = 1'b1; flush_tag_i = 4'd9; alloc_num_i = 3'd1;
    #1;
    check("R8 grant during mispredict", int'(alloc_ok_o), 0);
    step();
    alloc(1, 1, 10, "R6");
    finish(3'b111, 7, 8, 9, 3'b000);
    expect_ret(4'b0111, 7, "R6");
    finish(3'b001, 10, 0, 0, 3'b000);
    expect_ret(4'b0001, 10, "R6");
  endtask

  task automatic test_exc();
    alloc(4, 1, 11, "R2");
    finish(3'b111, 11, 12, 13, 3'b010);
    alloc_num_i = 3'd1;
    #1;
    check("R7 retire older", int'(ret_vld_o), 1);
    check("R7 retire tag", int'(ret_tag_o[3:0]), 11);
    check("R7 exception valid", int'(exc_vld_o), 1);
    check("R7 exception tag", int'(exc_tag_o), 12);
    check("R8 grant during exception", int'(alloc_ok_o), 0);
    step();
    expect_ret(4'b0000, 0, "R7 one cycle, emptied");
    alloc(1, 1, 12, "R7 flushed");
    finish(3'b001, 12, 0, 0, 3'b000);
    expect_ret(4'b0001, 12, "R4");
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk_i);
    #5 rst_ni = 1'b1;
    test_reset();
    test_inorder();
    test_full();
    test_flush();
    test_exc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule